// File: doc/BRIEF.md
# Parameterizable Reduced-Size AES Block Cipher

This block encrypts or decrypts one block with an AES-style cipher whose shape is chosen when it is built. The state is a grid of `ROWS` x `COLS` words, and each word is `WORD_W` bits wide (4 or 8). Rows and columns are each 1, 2 or 4. The number of rounds (1 to 10) and whether the last round mixes columns are also build-time choices. With the defaults (4x4 grid, 8-bit words, ten rounds, no mixing in the last round), the block computes standard AES-128.

A caller waits for `ready_o` and then pulses `start_i` for one cycle. That pulse carries the block, the key and the direction bit. The core runs one round per clock and derives round keys as it goes. For decryption it first steps the key schedule forward to the last round key, then walks the rounds backwards. The result appears on `data_o` together with a one-cycle `done_o`. It stays there until the next accepted start.

Field arithmetic uses GF(2^8) modulo x^8+x^4+x^3+x+1 for 8-bit words and GF(2^4) modulo x^4+x+1 for 4-bit words. The substitution is field inversion (zero maps to zero) followed by an affine map. For 8-bit words that map is the usual one with constant 0x63. For 4-bit words it is a ^ rotl(a,1) ^ rotl(a,2) ^ 0x6.

Top module: `sa_core`

## Requirements
- R1: With default parameters, encryption matches AES-128. The block is packed column-major, word (row r, column c) at index c*ROWS+r, with word 0 in the most significant bits. Key 000102...0f with plaintext 00112233...ff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R2: With default parameters and `decrypt_i`=1, each ciphertext in R1 returns its plaintext.
- R3: For the reduced shapes 2x2 with 4-bit words, four rounds and mixing in the last round; 4x1 with 8-bit words and three rounds; 1x4 with 4-bit words and one round: encryption changes the block, and decrypting the result with the same key restores the original block.
- R4: `done_o` rises exactly NUM_ROUNDS+1 cycles after the clock edge that accepts an encryption start, and exactly 2*NUM_ROUNDS+1 cycles after one that accepts a decryption start.
- R5: `done_o` is high for one cycle only. `ready_o` returns high in the same cycle as `done_o`. While `ready_o` is high and no start is given, `data_o` does not change.
- R6: A `start_i` given while `ready_o` is low is ignored. The running operation keeps its result and its timing.
- R7: While `rst_ni` is low, `ready_o` is 1, `done_o` is 0 and `data_o` is zero. This also holds when reset arrives in the middle of an operation.
- R8: An accepted start drives `ready_o` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while `ready_o` is high |
| decrypt_i | input | 1 | 1 selects decryption, 0 encryption; sampled with the start |
| data_i | input | ROWS*COLS*WORD_W | Input block, column-major, word 0 in the MSBs |
| key_i | input | ROWS*COLS*WORD_W | Cipher key, same packing as the block |
| ready_o | output | 1 | Core is idle and accepts a start |
| done_o | output | 1 | One-cycle pulse: `data_o` holds a new result |
| data_o | output | ROWS*COLS*WORD_W | Result block, held until the next accepted start |

## Verification
The assertions check the handshake on every cycle. They cover the exact latency of each direction, the one-cycle done pulse, ready returning only together with done, the drop of ready after an accepted start, and the stability of the output while idle. Properties cannot show whether the computed words are correct. That takes the bench scenarios: the known AES-128 vectors in both directions, and round trips through the reduced shapes. Those shapes cover a single column, where round keys are replayed from storage, a single row and 4-bit words. The bench scenarios also cover a start during a busy run and a reset in the middle of an operation.

// File: rtl/sa_pkg.sv
package sa_pkg;

  typedef logic [7:0] lut_t [256];

  // Field multiply; w selects GF(2^8) or GF(2^4)
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input int unsigned w);
    logic [8:0] sh;
    logic [8:0] poly;
    logic [7:0] acc;
    poly = (w == 8) ? 9'h11b : 9'h013;
    sh   = {1'b0, a};
    acc  = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh[7:0];
      sh = sh << 1;
      if (sh[w[3:0]]) sh = sh ^ poly;
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl_w(input logic [7:0] v, input int unsigned n,
                                        input int unsigned w);
    if (w == 8) return (v << n) | (v >> (8 - n));
    return {4'h0, (v[3:0] << n) | (v[3:0] >> (4 - n))};
  endfunction

  // Inversion (as a^(2^w-2)) followed by the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] a, input int unsigned w);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      if (i < int'(w)) begin
        p = gf_mul(p, p, w);
        r = gf_mul(r, p, w);
      end
    end
    if (w == 8)
      return r ^ rotl_w(r, 1, 8) ^ rotl_w(r, 2, 8) ^ rotl_w(r, 3, 8) ^ rotl_w(r, 4, 8) ^ 8'h63;
    return r ^ rotl_w(r, 1, 4) ^ rotl_w(r, 2, 4) ^ 8'h06;
  endfunction

  // Elaboration-time table; the inverse is built by scattering the forward one
  function automatic lut_t build_lut(input int unsigned w, input bit inv);
    lut_t t;
    logic [7:0] s;
    for (int v = 0; v < 256; v++) t[v] = '0;
    for (int v = 0; v < 256; v++) begin
      if (v < (1 << w)) begin
        s = sbox_calc(8'(v), w);
        if (inv) t[s] = 8'(v);
        else     t[v] = s;
      end
    end
    return t;
  endfunction

  // Round constant x^(rnd-1) in the chosen field
  function automatic logic [7:0] rcon_word(input int unsigned rnd, input int unsigned w);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 11; i++)
      if (i < int'(rnd)) r = gf_mul(r, 8'h02, w);
    return r;
  endfunction

  // Circulant coefficient for distance k along a column
  function automatic logic [7:0] mix_coef(input int unsigned rows, input int unsigned k,
                                          input bit inv);
    if (rows == 4) begin
      case (k)
        0:       return inv ? 8'h0e : 8'h02;
        1:       return inv ? 8'h0b : 8'h03;
        2:       return inv ? 8'h0d : 8'h01;
        default: return inv ? 8'h09 : 8'h01;
      endcase
    end
    if (rows == 2) return (k == 0) ? 8'h03 : 8'h02;
    return 8'h01;
  endfunction

endpackage

// File: rtl/sa_sub_layer.sv
module sa_sub_layer #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_WORDS = 16,
  parameter bit          INVERSE   = 1'b0
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  output logic [NUM_WORDS*WORD_W-1:0] words_o
);

  localparam sa_pkg::lut_t LUT = sa_pkg::build_lut(WORD_W, INVERSE);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [7:0] idx;
    assign idx = 8'(words_i[k*WORD_W +: WORD_W]);
    assign words_o[k*WORD_W +: WORD_W] = WORD_W'(LUT[idx]);
  end

endmodule

// File: rtl/sa_mix_layer.sv
module sa_mix_layer #(
  parameter int unsigned ROWS    = 4,
  parameter int unsigned COLS    = 4,
  parameter int unsigned WORD_W  = 8,
  parameter bit          INVERSE = 1'b0
) (
  input  logic [ROWS*COLS*WORD_W-1:0] state_i,
  output logic [ROWS*COLS*WORD_W-1:0] state_o
);

  localparam int unsigned BLK = ROWS * COLS * WORD_W;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [7:0] acc;
      always_comb begin
        acc = '0;
        for (int k = 0; k < ROWS; k++) begin
          acc = acc ^ sa_pkg::gf_mul(
                  sa_pkg::mix_coef(ROWS, (k + ROWS - r) % ROWS, INVERSE),
                  8'(state_i[BLK-1-(c*ROWS+k)*WORD_W -: WORD_W]), WORD_W);
        end
      end
      assign state_o[BLK-1-(c*ROWS+r)*WORD_W -: WORD_W] = acc[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/sa_key_step.sv
module sa_key_step #(
  parameter int unsigned ROWS    = 4,
  parameter int unsigned COLS    = 4,
  parameter int unsigned WORD_W  = 8,
  parameter bit          INVERSE = 1'b0
) (
  input  logic [ROWS*COLS*WORD_W-1:0] key_i,
  input  logic [WORD_W-1:0]           rcon_i,
  output logic [ROWS*COLS*WORD_W-1:0] key_o
);

  localparam int unsigned COL_W = ROWS * WORD_W;
  localparam int unsigned BLK   = COLS * COL_W;

  logic [COL_W-1:0] in_col  [COLS];
  logic [COL_W-1:0] out_col [COLS];
  logic [COL_W-1:0] last_col;
  logic [COL_W-1:0] rot_col;
  logic [COL_W-1:0] sub_col;
  logic [COL_W-1:0] tweak;

  for (genvar j = 0; j < COLS; j++) begin : g_split
    assign in_col[j] = key_i[BLK-1-j*COL_W -: COL_W];
    assign key_o[BLK-1-j*COL_W -: COL_W] = out_col[j];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rot
    assign rot_col[COL_W-1-r*WORD_W -: WORD_W] =
      last_col[COL_W-1-((r+1)%ROWS)*WORD_W -: WORD_W];
  end

  sa_sub_layer #(.WORD_W(WORD_W), .NUM_WORDS(ROWS), .INVERSE(1'b0)) u_sub (
    .words_i(rot_col),
    .words_o(sub_col)
  );

  assign tweak = sub_col ^ {rcon_i, {(COL_W-WORD_W){1'b0}}};

  if (!INVERSE) begin : g_fwd
    assign last_col   = in_col[COLS-1];
    assign out_col[0] = in_col[0] ^ tweak;
    for (genvar j = 1; j < COLS; j++) begin : g_chain
      assign out_col[j] = in_col[j] ^ out_col[j-1];
    end
  end else begin : g_bwd
    for (genvar j = 1; j < COLS; j++) begin : g_unchain
      assign out_col[j] = in_col[j] ^ in_col[j-1];
    end
    assign last_col   = out_col[COLS-1];
    assign out_col[0] = in_col[0] ^ tweak;
  end

endmodule

// File: rtl/sa_core.sv
module sa_core #(
  parameter int unsigned ROWS       = 4,
  parameter int unsigned COLS       = 4,
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned NUM_ROUNDS = 10,
  parameter bit          FINAL_MIX  = 1'b0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            decrypt_i,
  input  logic [ROWS*COLS*WORD_W-1:0]     data_i,
  input  logic [ROWS*COLS*WORD_W-1:0]     key_i,
  output logic                            ready_o,
  output logic                            done_o,
  output logic [ROWS*COLS*WORD_W-1:0]     data_o
);

  localparam int unsigned NW    = ROWS * COLS;
  localparam int unsigned BLK   = NW * WORD_W;
  localparam int unsigned CNT_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXPAND, ST_ROUND} state_e;

  state_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_q, dec_d;
  logic             done_q, done_d;
  logic [BLK-1:0]   blk_q, blk_d;
  logic [BLK-1:0]   rk_q, rk_d;

  logic             accept;
  logic             mix_on;
  logic [WORD_W-1:0] rcon_w;
  logic [BLK-1:0]   key_fwd, key_prev;
  logic [BLK-1:0]   sb_e, sr_e, mc_e, enc_out;
  logic [BLK-1:0]   ak_d, imc_d, pre_d, isr_d, dec_out;

  assign accept = start_i && (st_q == ST_IDLE);
  assign mix_on = (cnt_q != LAST) || FINAL_MIX;
  assign rcon_w = WORD_W'(sa_pkg::rcon_word(int'(cnt_q), WORD_W));

  // ---------------- key schedule ----------------
  sa_key_step #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .INVERSE(1'b0)) u_key_fwd (
    .key_i(rk_q), .rcon_i(rcon_w), .key_o(key_fwd)
  );

  if (COLS > 1) begin : g_key_back
    sa_key_step #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .INVERSE(1'b1)) u_key_bwd (
      .key_i(rk_q), .rcon_i(rcon_w), .key_o(key_prev)
    );
  end else begin : g_key_store
    // Single column: the schedule is not reversible, so replay stored keys
    logic [BLK-1:0]   store_q [NUM_ROUNDS];
    logic [CNT_W-1:0] rd_idx;
    logic             exp_we;
    assign exp_we = (st_q == ST_EXPAND) && (cnt_q != LAST);
    assign rd_idx = (cnt_q == '0) ? '0 : cnt_q - ONE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_ROUNDS; i++) store_q[i] <= '0;
      end else if (accept) begin
        store_q[0] <= key_i;
      end else if (exp_we) begin
        store_q[cnt_q] <= key_fwd;
      end
    end
    assign key_prev = store_q[rd_idx];
  end

  // ---------------- forward round ----------------
  sa_sub_layer #(.WORD_W(WORD_W), .NUM_WORDS(NW), .INVERSE(1'b0)) u_sub_fwd (
    .words_i(blk_q), .words_o(sb_e)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_shift_c
    for (genvar r = 0; r < ROWS; r++) begin : g_shift_r
      localparam int unsigned DST   = c * ROWS + r;
      localparam int unsigned SRC_E = ((c + r) % COLS) * ROWS + r;
      localparam int unsigned SRC_D = ((c + COLS - (r % COLS)) % COLS) * ROWS + r;
      assign sr_e[BLK-1-DST*WORD_W -: WORD_W]  = sb_e[BLK-1-SRC_E*WORD_W -: WORD_W];
      assign isr_d[BLK-1-DST*WORD_W -: WORD_W] = pre_d[BLK-1-SRC_D*WORD_W -: WORD_W];
    end
  end

  sa_mix_layer #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .INVERSE(1'b0)) u_mix_fwd (
    .state_i(sr_e), .state_o(mc_e)
  );

  assign enc_out = (mix_on ? mc_e : sr_e) ^ key_fwd;

  // ---------------- inverse round ----------------
  assign ak_d = blk_q ^ rk_q;

  sa_mix_layer #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .INVERSE(1'b1)) u_mix_inv (
    .state_i(ak_d), .state_o(imc_d)
  );

  assign pre_d = mix_on ? imc_d : ak_d;

  sa_sub_layer #(.WORD_W(WORD_W), .NUM_WORDS(NW), .INVERSE(1'b1)) u_sub_inv (
    .words_i(isr_d), .words_o(dec_out)
  );

  // ---------------- control ----------------
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    dec_d  = dec_q;
    blk_d  = blk_q;
    rk_d   = rk_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          dec_d = decrypt_i;
          rk_d  = key_i;
          cnt_d = ONE;
          blk_d = decrypt_i ? data_i : (data_i ^ key_i);
          st_d  = decrypt_i ? ST_EXPAND : ST_ROUND;
        end
      end
      ST_EXPAND: begin
        rk_d = key_fwd;
        if (cnt_q == LAST) st_d = ST_ROUND;
        else               cnt_d = cnt_q + ONE;
      end
      ST_ROUND: begin
        if (!dec_q) begin
          blk_d = enc_out;
          rk_d  = key_fwd;
          if (cnt_q == LAST) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          rk_d = key_prev;
          if (cnt_q == ONE) begin
            blk_d  = dec_out ^ key_prev;
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            blk_d = dec_out;
            cnt_d = cnt_q - ONE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
      blk_q  <= '0;
      rk_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      dec_q  <= dec_d;
      done_q <= done_d;
      blk_q  <= blk_d;
      rk_q   <= rk_d;
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = done_q;
  assign data_o  = blk_q;

endmodule

// File: rtl/sa_core_checker.sv
module sa_core_checker #(
  parameter int unsigned NUM_ROUNDS = 10,
  parameter int unsigned BLK        = 128
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           decrypt_i,
  input logic           ready_o,
  input logic           done_o,
  input logic [BLK-1:0] data_o
);

  localparam logic [5:0] LAT_ENC = 6'(NUM_ROUNDS + 1);
  localparam logic [5:0] LAT_DEC = 6'(2 * NUM_ROUNDS + 1);

  logic [5:0] lat_q;
  logic       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      mode_q <= 1'b0;
    end else if (start_i && ready_o) begin
      lat_q  <= 6'd1;
      mode_q <= decrypt_i;
    end else if (lat_q != 6'd0 && lat_q != 6'd63) begin
      lat_q  <= lat_q + 6'd1;
    end
  end

  // R4
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (mode_q ? LAT_DEC : LAT_ENC)));

  // R5
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  a_r5_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> done_o);

  // R5
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(data_o));

  // R8
  a_r8_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

endmodule

bind sa_core sa_core_checker #(.NUM_ROUNDS(NUM_ROUNDS), .BLK(ROWS*COLS*WORD_W)) u_sa_core_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .decrypt_i(decrypt_i),
  .ready_o(ready_o), .done_o(done_o), .data_o(data_o)
);

// File: tb/sa_core_bench.sv
module sa_rt_unit #(
  parameter int unsigned ROWS       = 2,
  parameter int unsigned COLS       = 2,
  parameter int unsigned WORD_W     = 4,
  parameter int unsigned NUM_ROUNDS = 4,
  parameter bit          FINAL_MIX  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   n_chk,
  output int   n_err
);
  localparam int unsigned BLK = ROWS * COLS * WORD_W;

  logic           start, dec, rdy, dn;
  logic [BLK-1:0] din, key, dout;

  sa_core #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .NUM_ROUNDS(NUM_ROUNDS),
            .FINAL_MIX(FINAL_MIX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .decrypt_i(dec), .data_i(din),
    .key_i(key), .ready_o(rdy), .done_o(dn), .data_o(dout)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s shape %0dx%0dx%0d: actual %h expected %h", tag, ROWS, COLS, WORD_W,
               act, exp);
    end
  endtask

  task automatic op(input logic m, input logic [BLK-1:0] d, output logic [BLK-1:0] r,
                    output int lat);
    @(negedge clk);
    start = 1'b1; dec = m; din = d;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!dn) begin
      @(negedge clk);
      lat++;
    end
    r = dout;
  endtask

  initial begin
    logic [BLK-1:0] pt, ct, back;
    int lat;
    fin = 1'b0; n_chk = 0; n_err = 0;
    start = 1'b0; dec = 1'b0; din = '0;
    key = BLK'(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    wait (rst_n);
    for (int p = 0; p < 2; p++) begin
      pt = (p == 0) ? '0 : BLK'(128'h0123456789abcdeffedcba9876543210);
      op(1'b0, pt, ct, lat);
      chk(ct != pt, "R3 encryption changes block", 128'(ct), 128'(pt));
      chk(lat == NUM_ROUNDS + 1, "R4 encrypt latency", 128'(lat), 128'(NUM_ROUNDS + 1));
      op(1'b1, ct, back, lat);
      chk(back == pt, "R3 round trip", 128'(back), 128'(pt));
      chk(lat == 2 * NUM_ROUNDS + 1, "R4 decrypt latency", 128'(lat),
          128'(2 * NUM_ROUNDS + 1));
    end
    fin = 1'b1;
  end
endmodule

module sa_core_bench;
  logic         clk, rst_n, rt_rst_n;
  logic         start, dec, rdy, dn;
  logic [127:0] din, key, dout;

  int n_checks = 0;
  int n_errors = 0;

  logic fin_b, fin_c, fin_d;
  int   chk_b, chk_c, chk_d, err_b, err_c, err_d;

  localparam logic [127:0] VEC_KEY [2] = '{128'h000102030405060708090a0b0c0d0e0f,
                                           128'h2b7e151628aed2a6abf7158809cf4f3c};
  localparam logic [127:0] VEC_PT  [2] = '{128'h00112233445566778899aabbccddeeff,
                                           128'h3243f6a8885a308d313198a2e0370734};
  localparam logic [127:0] VEC_CT  [2] = '{128'h69c4e0d86a7b0430d8cdb78070b4c55a,
                                           128'h3925841d02dc09fbdc118597196a0b32};

  sa_core u_sa_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .decrypt_i(dec), .data_i(din),
    .key_i(key), .ready_o(rdy), .done_o(dn), .data_o(dout)
  );

  sa_rt_unit #(.ROWS(2), .COLS(2), .WORD_W(4), .NUM_ROUNDS(4), .FINAL_MIX(1'b1)) u_rt_b (
    .clk(clk), .rst_n(rt_rst_n), .fin(fin_b), .n_chk(chk_b), .n_err(err_b));
  sa_rt_unit #(.ROWS(4), .COLS(1), .WORD_W(8), .NUM_ROUNDS(3), .FINAL_MIX(1'b0)) u_rt_c (
    .clk(clk), .rst_n(rt_rst_n), .fin(fin_c), .n_chk(chk_c), .n_err(err_c));
  sa_rt_unit #(.ROWS(1), .COLS(4), .WORD_W(4), .NUM_ROUNDS(1), .FINAL_MIX(1'b0)) u_rt_d (
    .clk(clk), .rst_n(rt_rst_n), .fin(fin_d), .n_chk(chk_d), .n_err(err_d));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + chk_b + chk_c + chk_d, n_errors + err_b + err_c + err_d);
  endtask

  task automatic run_op(input logic m, input logic [127:0] d, input logic [127:0] k,
                        output logic [127:0] r, output int lat);
    @(negedge clk);
    start = 1'b1; dec = m; din = d; key = k;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!dn) begin
      @(negedge clk);
      lat++;
    end
    r = dout;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL R4 watchdog: actual no completion expected done within limit");
    report();
    $finish;
  end

  initial begin
    logic [127:0] res, held;
    int lat;
    rst_n = 1'b0; rt_rst_n = 1'b0;
    start = 1'b0; dec = 1'b0; din = '0; key = '0;
    repeat (3) @(negedge clk);
    check(rdy == 1'b1, "R7 reset ready", 128'(rdy), 128'd1);
    check(dn == 1'b0, "R7 reset done", 128'(dn), 128'd0);
    check(dout == '0, "R7 reset data", dout, 128'd0);
    rst_n = 1'b1; rt_rst_n = 1'b1;

    // Known vectors, both directions (R1, R2, R4)
    for (int i = 0; i < 2; i++) begin
      run_op(1'b0, VEC_PT[i], VEC_KEY[i], res, lat);
      check(res == VEC_CT[i], "R1 encrypt vector", res, VEC_CT[i]);
      check(lat == 11, "R4 encrypt latency", 128'(lat), 128'd11);
      run_op(1'b1, VEC_CT[i], VEC_KEY[i], res, lat);
      check(res == VEC_PT[i], "R2 decrypt vector", res, VEC_PT[i]);
      check(lat == 21, "R4 decrypt latency", 128'(lat), 128'd21);
    end

    // R5: single-cycle done, output held while idle
    held = dout;
    @(negedge clk);
    check(dn == 1'b0, "R5 done one cycle", 128'(dn), 128'd0);
    repeat (4) @(negedge clk);
    check(dout == held, "R5 output held", dout, held);

    // R6 / R8: start while busy is ignored
    @(negedge clk);
    start = 1'b1; dec = 1'b0; din = VEC_PT[1]; key = VEC_KEY[1];
    @(negedge clk);
    start = 1'b0;
    check(rdy == 1'b0, "R8 ready drops after start", 128'(rdy), 128'd0);
    @(negedge clk);
    start = 1'b1; dec = 1'b1; din = VEC_PT[0]; key = VEC_KEY[0];
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!dn) begin
      @(negedge clk);
      lat++;
    end
    check(dout == VEC_CT[1], "R6 busy start ignored result", dout, VEC_CT[1]);
    check(lat == 11, "R6 busy start ignored timing", 128'(lat), 128'd11);

    // R7: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; dec = 1'b1; din = VEC_CT[0]; key = VEC_KEY[0];
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rdy == 1'b1, "R7 mid-run reset ready", 128'(rdy), 128'd1);
    check(dn == 1'b0, "R7 mid-run reset done", 128'(dn), 128'd0);
    check(dout == '0, "R7 mid-run reset data", dout, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(1'b0, VEC_PT[0], VEC_KEY[0], res, lat);
    check(res == VEC_CT[0], "R1 encrypt after reset", res, VEC_CT[0]);

    wait (fin_b && fin_c && fin_d);
    @(negedge clk);
    report();
    $finish;
  end
endmodule